// File: doc/BRIEF.md
# Staged Serial Clock Start-up Controller

This block holds the global control word and runs the start-up sequence for the two high-frequency clock generators of a serial audio port, one for the transmit section and one for the receive section. Each generator is a programmable divider running from the audio master clock. It is held in reset until software sets its release bit in the global control word. Software then polls the control word until the bit reads back as set. Only then has the release crossed into the audio clock domain, and only then can the next start-up step begin.

A divide ratio of zero (divide-by-1) is the reset value. At that ratio the master clock goes straight to the output whether or not the release bit is set. A new ratio written while a divider runs is picked up only when the divider next sits in reset. Four pins (two high-frequency clocks and two frame syncs) have per-pin direction bits. A pin drives only when its direction bit selects output. The levels on the pins can be read back through a synchronizer.

Top module: `sclk_startup_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0 and `pin_o` is 0.
- R2: Global control at address 0 has bit 0 as the receive divider release and bit 1 as the transmit divider release. A read returns the value that has been synchronized into the audio domain and back. With `pclk` and `aclk` in phase, a write on edge P0 becomes visible after edge P4 and not before.
- R3: The transmit ratio register is at address 1 and the receive ratio register is at address 2. Each keeps `wdata[11:0]`, drops the upper bits and reads back after the write edge.
- R4: With ratio N≥1, a released divider outputs a period of N+1 `aclk` cycles, high for the first (N+2)/2 (integer division) of them. When the release is written on edge P0, the output is first high after edge P3.
- R5: With a latched ratio of 0, the divider output follows `aclk` directly, whether the release bit is 0 or 1.
- R6: With ratio N≥1 and the release bit at 0, the divider output stays low.
- R7: A ratio written while its divider is released has no effect on the output until the release bit is cleared and set again.
- R8: The direction register is at address 3. Bit 0 is the transmit clock pin, bit 1 the receive clock pin, bit 2 the transmit frame-sync pin and bit 3 the receive frame-sync pin. `pin_oe` equals these bits. Each `pin_o` bit carries its source (frame syncs from `fs_tx_src` and `fs_rx_src`) when its direction bit is 1 and is 0 when it is 0.
- R9: Address 4 returns `pin_i` (same bit order as R8) through two `pclk` flops. A level applied before edge P1 reads back after P2 and not after P1.
- R10: Writing 0 to global control on edge P0 makes both divider outputs low after edge P3 and the control word read back 0 after edge P4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register clock |
| aclk | input | 1 | Audio master clock feeding the dividers |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| fs_tx_src | input | 1 | Internal transmit frame-sync source |
| fs_rx_src | input | 1 | Internal receive frame-sync source |
| pin_i | input | 4 | Levels present on the four pins |
| pin_o | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables (1 = drive) |

## Verification
Each result has a fixed latency from the write edge P0. The direction and ratio registers read back and drive `pin_oe` right after P0. A released divider first goes high after P3, and a cleared divider falls low after P3. The control read-back changes after P4, and pin levels read back after P2. The bench counts falling edges from the stimulus and checks the cycle just before each change as well as the cycle it is due in. Divider waveforms are compared sample by sample against an (N+1)-cycle pattern computed in the bench for every ratio from 1 to 7 in both sections.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [2:0] {
        ADR_GCTL  = 3'd0,
        ADR_TXDIV = 3'd1,
        ADR_RXDIV = 3'd2,
        ADR_PDIR  = 3'd3,
        ADR_PSTAT = 3'd4
    } adr_e;

    localparam int unsigned GB_RX   = 0;
    localparam int unsigned GB_TX   = 1;
    localparam int unsigned NSEC    = 2;

    localparam int unsigned PIN_TXH = 0;
    localparam int unsigned PIN_RXH = 1;
    localparam int unsigned PIN_TXF = 2;
    localparam int unsigned PIN_RXF = 3;
    localparam int unsigned NPIN    = 4;

endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
    import sclk_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned RATIO_W = 12
) (
    input  logic               pclk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NSEC-1:0]    rel_fb_i,
    input  logic [NPIN-1:0]    pin_i,
    output logic [NSEC-1:0]    rel_o,
    output logic [RATIO_W-1:0] ratio_tx_o,
    output logic [RATIO_W-1:0] ratio_rx_o,
    output logic [NPIN-1:0]    dir_o
);

    typedef struct packed {
        logic [NSEC-1:0]    gctl;
        logic [RATIO_W-1:0] rtx;
        logic [RATIO_W-1:0] rrx;
        logic [NPIN-1:0]    dir;
        logic [NSEC-1:0]    fb1;
        logic [NSEC-1:0]    fb2;
        logic [NPIN-1:0]    ps1;
        logic [NPIN-1:0]    ps2;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.fb1 = rel_fb_i;
        st_d.fb2 = st_q.fb1;
        st_d.ps1 = pin_i;
        st_d.ps2 = st_q.ps1;
        if (wr_en) begin
            case (adr_e'(addr))
                ADR_GCTL:  st_d.gctl = wdata[NSEC-1:0];
                ADR_TXDIV: st_d.rtx  = wdata[RATIO_W-1:0];
                ADR_RXDIV: st_d.rrx  = wdata[RATIO_W-1:0];
                ADR_PDIR:  st_d.dir  = wdata[NPIN-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (adr_e'(addr))
            ADR_GCTL:  rdata[NSEC-1:0]    = st_q.fb2;
            ADR_TXDIV: rdata[RATIO_W-1:0] = st_q.rtx;
            ADR_RXDIV: rdata[RATIO_W-1:0] = st_q.rrx;
            ADR_PDIR:  rdata[NPIN-1:0]    = st_q.dir;
            ADR_PSTAT: rdata[NPIN-1:0]    = st_q.ps2;
            default:   rdata = '0;
        endcase
    end

    assign rel_o      = st_q.gctl;
    assign ratio_tx_o = st_q.rtx;
    assign ratio_rx_o = st_q.rrx;
    assign dir_o      = st_q.dir;

    AST_GCTL_CLEAR: assert property (@(posedge pclk) disable iff (!rst_n)
        (wr_en && addr == ADR_GCTL && wdata[NSEC-1:0] == '0) |=> (rel_o == '0)); // R10
    AST_DIR_HOLD: assert property (@(posedge pclk) disable iff (!rst_n)
        (!wr_en) |=> $stable(dir_o)); // R8

endmodule

// File: rtl/sclk_hdiv.sv
module sclk_hdiv #(
    parameter int unsigned RATIO_W     = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               aclk,
    input  logic               rst_n,
    input  logic               rel_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               rel_a_o,
    output logic               clk_o
);

    localparam int unsigned HW = RATIO_W + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [RATIO_W-1:0]     cnt;
        logic [RATIO_W-1:0]     ratio;
        logic                   out;
    } div_t;

    div_t       dv_d, dv_q;
    logic       rel_a;
    logic [HW-1:0] half;

    assign rel_a = dv_q.sync[SYNC_STAGES-1];
    assign half  = ({1'b0, dv_q.ratio} + HW'(2)) >> 1;

    always_comb begin
        dv_d      = dv_q;
        dv_d.sync = {dv_q.sync[SYNC_STAGES-2:0], rel_i};
        if (!rel_a) begin
            dv_d.cnt   = '0;
            dv_d.out   = 1'b0;
            dv_d.ratio = ratio_i;
        end else begin
            dv_d.cnt = (dv_q.cnt == dv_q.ratio) ? '0 : dv_q.cnt + RATIO_W'(1);
            dv_d.out = ({1'b0, dv_q.cnt} < half);
        end
    end

    always_ff @(posedge aclk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign rel_a_o = rel_a;
    assign clk_o   = (dv_q.ratio == '0) ? aclk : dv_q.out;

    AST_HELD_LOW: assert property (@(posedge aclk) disable iff (!rst_n)
        (!rel_a) |=> !dv_q.out); // R6
    AST_CNT_RANGE: assert property (@(posedge aclk) disable iff (!rst_n)
        dv_q.cnt <= dv_q.ratio); // R4
    AST_FIRST_HIGH: assert property (@(posedge aclk) disable iff (!rst_n)
        $rose(rel_a) |=> dv_q.out); // R4
    AST_RATIO_FROZEN: assert property (@(posedge aclk) disable iff (!rst_n)
        $past(rel_a) |-> $stable(dv_q.ratio)); // R7

endmodule

// File: rtl/sclk_pinmux.sv
module sclk_pinmux #(
    parameter int unsigned NP = 4
) (
    input  logic [NP-1:0] dir_i,
    input  logic [NP-1:0] src_i,
    output logic [NP-1:0] pin_o,
    output logic [NP-1:0] pin_oe
);

    for (genvar p = 0; p < NP; p++) begin : g_pin
        assign pin_oe[p] = dir_i[p];
        assign pin_o[p]  = dir_i[p] & src_i[p];
    end

endmodule

// File: rtl/sclk_startup_ctrl.sv
module sclk_startup_ctrl
    import sclk_pkg::*;
#(
    parameter int unsigned DW          = 32,
    parameter int unsigned RATIO_W     = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            pclk,
    input  logic            aclk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            fs_tx_src,
    input  logic            fs_rx_src,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] pin_o,
    output logic [NPIN-1:0] pin_oe
);

    logic [NSEC-1:0]    rel;
    logic [NSEC-1:0]    rel_fb;
    logic [NSEC-1:0]    sec_clk;
    logic [RATIO_W-1:0] ratio_tx;
    logic [RATIO_W-1:0] ratio_rx;
    logic [RATIO_W-1:0] ratio_sec [NSEC];
    logic [NPIN-1:0]    dir;
    logic [NPIN-1:0]    src;

    sclk_regs #(.DW(DW), .RATIO_W(RATIO_W)) u_regs (
        .pclk       (pclk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rel_fb_i   (rel_fb),
        .pin_i      (pin_i),
        .rel_o      (rel),
        .ratio_tx_o (ratio_tx),
        .ratio_rx_o (ratio_rx),
        .dir_o      (dir)
    );

    assign ratio_sec[GB_RX] = ratio_rx;
    assign ratio_sec[GB_TX] = ratio_tx;

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        sclk_hdiv #(.RATIO_W(RATIO_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
            .aclk    (aclk),
            .rst_n   (rst_n),
            .rel_i   (rel[g]),
            .ratio_i (ratio_sec[g]),
            .rel_a_o (rel_fb[g]),
            .clk_o   (sec_clk[g])
        );
    end

    assign src[PIN_TXH] = sec_clk[GB_TX];
    assign src[PIN_RXH] = sec_clk[GB_RX];
    assign src[PIN_TXF] = fs_tx_src;
    assign src[PIN_RXF] = fs_rx_src;

    sclk_pinmux #(.NP(NPIN)) u_pins (
        .dir_i  (dir),
        .src_i  (src),
        .pin_o  (pin_o),
        .pin_oe (pin_oe)
    );

endmodule

// File: tb/sclk_startup_ctrl_tb_top.sv
`timescale 1ns/1ps
module sclk_startup_ctrl_tb_top;

    logic        pclk = 1'b0;
    logic        aclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fs_tx_src = 1'b0;
    logic        fs_rx_src = 1'b0;
    logic [3:0]  pin_i = 4'd0;
    logic [3:0]  pin_o;
    logic [3:0]  pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 begin
        pclk = ~pclk;
        aclk = ~aclk;
    end

    sclk_startup_ctrl dut_i (
        .pclk(pclk), .aclk(aclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fs_tx_src(fs_tx_src), .fs_rx_src(fs_rx_src),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge pclk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge pclk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic count_rises(input int pin, input int samples, output int r);
        logic prev;
        r = 0;
        @(negedge pclk);
        prev = pin_o[pin];
        for (int s = 1; s < samples; s++) begin
            @(negedge pclk);
            if (!prev && pin_o[pin]) r++;
            prev = pin_o[pin];
        end
    endtask

    // Release one section with ratio n; check waveform (R4) and quiet neighbour (R6)
    task automatic sweep_one(input int pin, input int relbit, input int n);
        int h;
        logic ex;
        wr(3'd0, 32'd0);
        idle(6);
        wr(3'd1, n);
        wr(3'd2, n);
        idle(2);
        wr(3'd0, 32'(1 << relbit));
        h = (n + 2) / 2;
        for (int k = 1; k <= 3 * (n + 1) + 3; k++) begin
            @(negedge pclk);
            ex = (k < 3) ? 1'b0 : (((k - 3) % (n + 1)) < h);
            chk("R4 divider waveform", pin_o[pin], ex);
            chk("R6 unreleased divider low", pin_o[pin ^ 1], 0);
        end
    endtask

    initial begin
        int r;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        for (int a = 0; a < 5; a++) rdchk("R1 reset register", 3'(a), 0);
        chk("R1 reset pin_oe", pin_oe, 0);
        chk("R1 reset pin_o", pin_o, 0);

        // R3 ratio registers, 12 bits kept
        wr(3'd1, 32'h0000_0ABC); rdchk("R3 tx ratio", 3'd1, 32'h0ABC);
        wr(3'd1, 32'hFFFF_F123); rdchk("R3 tx ratio truncate", 3'd1, 32'h0123);
        wr(3'd2, 32'h0000_0FFF); rdchk("R3 rx ratio", 3'd2, 32'h0FFF);
        wr(3'd2, 32'h0000_1005); rdchk("R3 rx ratio truncate", 3'd2, 32'h0005);

        // R8 direction all out for the divider tests
        wr(3'd3, 32'hF);
        rdchk("R8 dir readback", 3'd3, 32'hF);
        chk("R8 pin_oe follows dir", pin_oe, 4'hF);

        // R2 read-back latency: write tx release on P0, visible after P4
        wr(3'd1, 32'd3);
        idle(2);
        wr(3'd0, 32'd2);
        for (int k = 1; k <= 4; k++) begin
            @(negedge pclk);
            #1;
            chk("R2 gctl readback latency", rdata, (k < 4) ? 32'd0 : 32'd2);
        end

        // R4/R6 sweep both sections
        for (int n = 1; n <= 7; n++) begin
            sweep_one(0, 1, n);
            sweep_one(1, 0, n);
        end

        // R7 ratio change while running
        sweep_one(0, 1, 3);
        wr(3'd1, 32'd5);
        count_rises(0, 41, r);
        chk("R7 ratio held while released", r, 10);
        wr(3'd0, 32'd0);
        idle(6);
        wr(3'd0, 32'd2);
        idle(4);
        count_rises(0, 61, r);
        chk("R7 new ratio after re-release", r, 10);

        // R5 divide-by-1 bypass, not gated by release
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd0);
        idle(6);
        for (int rel = 0; rel < 2; rel++) begin
            if (rel == 1) begin
                wr(3'd0, 32'd1);
                idle(6);
            end
            repeat (3) begin
                @(posedge aclk); #1.25;
                chk("R5 bypass high phase", pin_o[1], 1);
                @(negedge aclk); #1.25;
                chk("R5 bypass low phase", pin_o[1], 0);
            end
        end

        // R10 write zero stops both dividers
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd2);
        wr(3'd2, 32'd2);
        idle(6);
        wr(3'd0, 32'd3);
        idle(10);
        wr(3'd0, 32'd0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge pclk);
            #1;
            if (k >= 3) begin
                chk("R10 tx clock stopped", pin_o[0], 0);
                chk("R10 rx clock stopped", pin_o[1], 0);
            end
            if (k >= 4) chk("R10 gctl reads zero", rdata, 0);
        end

        // R8 frame-sync and clock pin gating by direction
        wr(3'd3, 32'h4);
        fs_tx_src = 1'b1; #1;
        chk("R8 fs tx driven", pin_o[2], 1);
        chk("R8 oe pattern", pin_oe, 4'h4);
        fs_tx_src = 1'b0; #1;
        chk("R8 fs tx follows source", pin_o[2], 0);
        wr(3'd3, 32'h0);
        fs_tx_src = 1'b1; fs_rx_src = 1'b1; #1;
        chk("R8 fs pins quiet when input", pin_o, 0);
        chk("R8 oe off", pin_oe, 0);
        wr(3'd0, 32'd2);
        idle(6);
        r = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge pclk);
            if (pin_o[0]) r++;
        end
        chk("R8 clock pin quiet when input", r, 0);
        wr(3'd3, 32'h1);
        r = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge pclk);
            if (pin_o[0]) r++;
        end
        chk("R8 clock pin toggles when output", (r > 0) ? 1 : 0, 1);

        // R9 pin status through two flops
        @(negedge pclk);
        addr = 3'd4;
        pin_i = 4'b1010;
        @(negedge pclk); #1;
        chk("R9 pin status not yet", rdata, 0);
        @(negedge pclk); #1;
        chk("R9 pin status after two", rdata, 32'hA);
        pin_i = 4'b0101;
        @(negedge pclk); #1;
        chk("R9 pin status hold", rdata, 32'hA);
        @(negedge pclk); #1;
        chk("R9 pin status update", rdata, 32'h5);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule